// File: doc/BRIEF.md
# Command Port Register Override Controller

This block sits at the command port of a content-addressable memory device. The port carries a 16-bit data word and two active-high strobes, one for command writes and one for command reads. By default the block sends every command write on to the instruction decoder as a one-cycle pulse carrying the word. A command read returns the device status word, which the block receives from outside.

One instruction, the register override, redirects exactly one later command cycle to an internal register. That cycle can be a read or a write. A write loads the register and a read returns its contents. When that cycle's strobe falls, routing goes back to the default. The block holds the configuration registers, keeping foreground and background copies of the banked ones, and switches between the two copies on two bank-select instructions. The page registers are loaded by the device's paging logic. The flag word comes in from outside. These three registers can be read through the override but never written through it.

Top module: `cmd_port_ovr`

## Requirements
- R1: After reset no override is pending, `cmd_rdata` equals `status_in`, `instr_valid` is 0, the foreground bank is active and every configuration output is 0.
- R2: A command write with no override pending raises `instr_valid` for exactly one clock, the clock after the strobe's rising edge, with the written word on `instr_word`. No register changes. When an override is pending, a command write is not forwarded.
- R3: A written word W arms an override only when (W & 16'hFFC7) == 16'h0200. The target code is W[5:3]. Any other word, for example 16'h0201, leaves routing at the default.
- R4: While an override is pending, `cmd_rdata` shows the target register. Otherwise it shows `status_in`. Target codes: 0 control, 1 segment control, 2 address, 3 mask one, 4 mask two, 5 page-source, 6 page-destination, 7 flags (`flags_in`).
- R5: An overridden write to target codes 0 to 4 stores the word in that register. For codes 0 to 3 this is the active bank's copy. Mask two has a single copy.
- R6: An overridden write to target codes 5, 6 or 7 changes no register and is not forwarded, but it still uses up the override.
- R7: The override is used up by the first command cycle that starts after the cycle that armed it. Routing returns to default on the clock after that cycle's strobe falls. The falling edge of the arming write does not clear it.
- R8: A read of target code 5 returns the DEV_ID parameter on bits 15..4 and the active bank's 4-bit page-source value on bits 3..0.
- R9: Word 16'h0601 selects the background bank and 16'h0600 selects the foreground bank, from the clock after the strobe rises. The configuration outputs and overridden accesses then use the selected copies. Mask two and flags are shared by both banks.
- R10: `page_we[0]` loads `page_data[3:0]` into the active bank's page-source register and `page_we[1]` loads `page_data` into its page-destination register, on the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command write strobe, high for one cycle |
| cmd_rd | input | 1 | Command read strobe, high for one cycle |
| cmd_wdata | input | 16 | Command write data |
| status_in | input | 16 | Device status word for default reads |
| flags_in | input | 16 | Flag word, readable as target 7 |
| page_we | input | 2 | Page register load enables (bit 0 source, bit 1 destination) |
| page_data | input | 16 | Page register load data |
| cmd_rdata | output | 16 | Command read data |
| instr_valid | output | 1 | Pulse: forwarded instruction word valid |
| instr_word | output | 16 | Forwarded instruction word |
| bank_bg | output | 1 | 1 when the background bank is active |
| cfg_ctrl | output | 16 | Active control register |
| cfg_seg | output | 16 | Active segment control register |
| cfg_addr | output | 16 | Active address register |
| cfg_mask1 | output | 16 | Active mask one register |
| cfg_mask2 | output | 16 | Shared mask two register |

## Verification
The assertions check four things on every clock. The override must clear on the falling strobe of the cycle that used it. A forward pulse must never follow a write made under override. A write to a read-only target must leave the page registers unchanged. Stored values must land one clock after a write or a page load.

Some behaviour can only be shown by the bench's scenarios. These are: the one-shot nature seen across a sequence of reads, the near-miss opcode that must not arm an override, the device ID in the page-source read, and bank switching that restores values written earlier to the other copy.

// File: rtl/cmdport_pkg.sv
package cmdport_pkg;
   typedef enum logic [2:0] {
      TGT_CTRL  = 3'd0,
      TGT_SEG   = 3'd1,
      TGT_ADDR  = 3'd2,
      TGT_MASK1 = 3'd3,
      TGT_MASK2 = 3'd4,
      TGT_PSRC  = 3'd5,
      TGT_PDST  = 3'd6,
      TGT_FLAGS = 3'd7
   } tgt_e;

   localparam logic [15:0] OP_SEL_FG = 16'h0600;
   localparam logic [15:0] OP_SEL_BG = 16'h0601;

   // override word: fixed bits 15..6 and 2..0, target in 5..3
   function automatic logic is_override(input logic [15:0] w);
      return (w[15:6] == 10'h008) && (w[2:0] == 3'b000);
   endfunction

   function automatic logic is_writable(input tgt_e t);
      return (t <= TGT_MASK2);
   endfunction
endpackage

// File: rtl/cmd_strobe_edge.sv
module cmd_strobe_edge #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] strobe,
   output logic [N-1:0] rise,
   output logic [N-1:0] fall
);
   if (N < 1) begin : g_bad_n
      $error("cmd_strobe_edge: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_bit
      logic prev_q;
      always_ff @(posedge clk) begin
         if (!rst_n) prev_q <= 1'b0;
         else        prev_q <= strobe[i];
      end
      assign rise[i] = strobe[i] & ~prev_q;
      assign fall[i] = ~strobe[i] & prev_q;
   end
endmodule

// File: rtl/cmd_route_ctrl.sv
module cmd_route_ctrl
   import cmdport_pkg::*;
#(
   parameter int CMD_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_rise,
   input  logic             rd_rise,
   input  logic             any_fall,
   input  logic [CMD_W-1:0] wdata,
   output logic             ovr_active,
   output tgt_e             ovr_tgt,
   output logic             ovr_wr,
   output logic             fwd_valid,
   output logic [CMD_W-1:0] fwd_word,
   output logic             bank_bg
);
   if (CMD_W != 16) begin : g_bad_w
      $error("cmd_route_ctrl: command word must be 16 bits");
   end

   logic used_q;

   assign ovr_wr = wr_rise & ovr_active;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ovr_active <= 1'b0;
         ovr_tgt    <= TGT_CTRL;
         used_q     <= 1'b0;
         fwd_valid  <= 1'b0;
         fwd_word   <= '0;
         bank_bg    <= 1'b0;
      end else begin
         fwd_valid <= 1'b0;
         if (wr_rise && !ovr_active) begin
            fwd_valid <= 1'b1;
            fwd_word  <= wdata;
            if (is_override(wdata)) begin
               ovr_active <= 1'b1;
               ovr_tgt    <= tgt_e'(wdata[5:3]);
            end
            if (wdata == OP_SEL_FG)      bank_bg <= 1'b0;
            else if (wdata == OP_SEL_BG) bank_bg <= 1'b1;
         end
         if (ovr_active && (wr_rise || rd_rise)) used_q <= 1'b1;
         if (ovr_active && used_q && any_fall) begin
            ovr_active <= 1'b0;
            used_q     <= 1'b0;
         end
      end
   end

   a_r7_clear_after_use: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_active && used_q && any_fall) |=> !ovr_active);

   a_r2_no_forward_under_ovr: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_rise && ovr_active) |=> !fwd_valid);

   a_r9_bg_select: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_rise && !ovr_active && wdata == OP_SEL_BG) |=> bank_bg);
endmodule

// File: rtl/cmd_reg_bank.sv
module cmd_reg_bank
   import cmdport_pkg::*;
#(
   parameter int          W      = 16,
   parameter int          PAGE_W = 4,
   parameter int          BANKS  = 2,
   parameter logic [W-PAGE_W-1:0] DEV_ID = '1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bank_bg,
   input  logic          we,
   input  tgt_e          wsel,
   input  logic [W-1:0]  wdata,
   input  logic [1:0]    page_we,
   input  logic [W-1:0]  page_data,
   input  logic [W-1:0]  flags_in,
   input  tgt_e          rsel,
   output logic [W-1:0]  rdata,
   output logic [W-1:0]  cfg_ctrl,
   output logic [W-1:0]  cfg_seg,
   output logic [W-1:0]  cfg_addr,
   output logic [W-1:0]  cfg_mask1,
   output logic [W-1:0]  cfg_mask2
);
   localparam int SEL_W = (BANKS > 1) ? $clog2(BANKS) : 1;

   if (BANKS != 2) begin : g_bad_banks
      $error("cmd_reg_bank: exactly two banks are supported");
   end
   if (PAGE_W < 1 || PAGE_W >= W) begin : g_bad_page
      $error("cmd_reg_bank: PAGE_W out of range");
   end

   logic [W-1:0]      ctrl_a  [BANKS];
   logic [W-1:0]      seg_a   [BANKS];
   logic [W-1:0]      addr_a  [BANKS];
   logic [W-1:0]      mask1_a [BANKS];
   logic [PAGE_W-1:0] psrc_a  [BANKS];
   logic [W-1:0]      pdst_a  [BANKS];
   logic [W-1:0]      mask2_q;
   logic [SEL_W-1:0]  act;

   assign act = SEL_W'(bank_bg);

   for (genvar b = 0; b < BANKS; b++) begin : g_bank
      logic [W-1:0]      ctrl_r, seg_r, addr_r, mask1_r, pdst_r;
      logic [PAGE_W-1:0] psrc_r;
      logic              mine;
      assign mine = (act == SEL_W'(b));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ctrl_r  <= '0;
            seg_r   <= '0;
            addr_r  <= '0;
            mask1_r <= '0;
            psrc_r  <= '0;
            pdst_r  <= '0;
         end else begin
            if (mine && we) begin
               case (wsel)
                  TGT_CTRL:  ctrl_r  <= wdata;
                  TGT_SEG:   seg_r   <= wdata;
                  TGT_ADDR:  addr_r  <= wdata;
                  TGT_MASK1: mask1_r <= wdata;
                  default: ;
               endcase
            end
            if (mine && page_we[0]) psrc_r <= page_data[PAGE_W-1:0];
            if (mine && page_we[1]) pdst_r <= page_data;
         end
      end
      assign ctrl_a[b]  = ctrl_r;
      assign seg_a[b]   = seg_r;
      assign addr_a[b]  = addr_r;
      assign mask1_a[b] = mask1_r;
      assign psrc_a[b]  = psrc_r;
      assign pdst_a[b]  = pdst_r;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                        mask2_q <= '0;
      else if (we && wsel == TGT_MASK2)  mask2_q <= wdata;
   end

   assign cfg_ctrl  = ctrl_a[act];
   assign cfg_seg   = seg_a[act];
   assign cfg_addr  = addr_a[act];
   assign cfg_mask1 = mask1_a[act];
   assign cfg_mask2 = mask2_q;

   always_comb begin
      case (rsel)
         TGT_CTRL:  rdata = ctrl_a[act];
         TGT_SEG:   rdata = seg_a[act];
         TGT_ADDR:  rdata = addr_a[act];
         TGT_MASK1: rdata = mask1_a[act];
         TGT_MASK2: rdata = mask2_q;
         TGT_PSRC:  rdata = {DEV_ID, psrc_a[act]};
         TGT_PDST:  rdata = pdst_a[act];
         default:   rdata = flags_in;
      endcase
   end

   a_r5_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (we && wsel == TGT_CTRL) |=> (cfg_ctrl == $past(wdata)));

   a_r6_read_only_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !is_writable(wsel) && page_we == 2'b00)
      |=> ($stable(psrc_a[act]) && $stable(pdst_a[act])));

   a_r10_page_load: assert property (@(posedge clk) disable iff (!rst_n)
      page_we[0] |=> ((psrc_a[act] == $past(page_data[PAGE_W-1:0]))
                      || (bank_bg != $past(bank_bg))));
endmodule

// File: rtl/cmd_port_ovr.sv
module cmd_port_ovr
   import cmdport_pkg::*;
#(
   parameter int                 CMD_W  = 16,
   parameter int                 PAGE_W = 4,
   parameter logic [CMD_W-PAGE_W-1:0] DEV_ID = 12'hA5C
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_wr,
   input  logic             cmd_rd,
   input  logic [CMD_W-1:0] cmd_wdata,
   input  logic [CMD_W-1:0] status_in,
   input  logic [CMD_W-1:0] flags_in,
   input  logic [1:0]       page_we,
   input  logic [CMD_W-1:0] page_data,
   output logic [CMD_W-1:0] cmd_rdata,
   output logic             instr_valid,
   output logic [CMD_W-1:0] instr_word,
   output logic             bank_bg,
   output logic [CMD_W-1:0] cfg_ctrl,
   output logic [CMD_W-1:0] cfg_seg,
   output logic [CMD_W-1:0] cfg_addr,
   output logic [CMD_W-1:0] cfg_mask1,
   output logic [CMD_W-1:0] cfg_mask2
);
   localparam int STB_WR = 0;
   localparam int STB_RD = 1;

   logic [1:0]       rise, fall;
   logic             ovr_active, ovr_wr;
   tgt_e             ovr_tgt;
   logic [CMD_W-1:0] reg_rdata;

   cmd_strobe_edge #(.N(2)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .strobe ({cmd_rd, cmd_wr}),
      .rise   (rise),
      .fall   (fall)
   );

   cmd_route_ctrl #(.CMD_W(CMD_W)) u_route (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_rise    (rise[STB_WR]),
      .rd_rise    (rise[STB_RD]),
      .any_fall   (|fall),
      .wdata      (cmd_wdata),
      .ovr_active (ovr_active),
      .ovr_tgt    (ovr_tgt),
      .ovr_wr     (ovr_wr),
      .fwd_valid  (instr_valid),
      .fwd_word   (instr_word),
      .bank_bg    (bank_bg)
   );

   cmd_reg_bank #(.W(CMD_W), .PAGE_W(PAGE_W), .BANKS(2), .DEV_ID(DEV_ID)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bank_bg   (bank_bg),
      .we        (ovr_wr),
      .wsel      (ovr_tgt),
      .wdata     (cmd_wdata),
      .page_we   (page_we),
      .page_data (page_data),
      .flags_in  (flags_in),
      .rsel      (ovr_tgt),
      .rdata     (reg_rdata),
      .cfg_ctrl  (cfg_ctrl),
      .cfg_seg   (cfg_seg),
      .cfg_addr  (cfg_addr),
      .cfg_mask1 (cfg_mask1),
      .cfg_mask2 (cfg_mask2)
   );

   assign cmd_rdata = ovr_active ? reg_rdata : status_in;

   a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      instr_valid |=> !instr_valid);
endmodule

// File: tb/test_cmd_port_ovr.sv
module test_cmd_port_ovr;
   localparam logic [11:0] DEV = 12'hA5C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_wr = 1'b0, cmd_rd = 1'b0;
   logic [15:0] cmd_wdata = '0, status_in = 16'h5A01, flags_in = 16'h00F3;
   logic [1:0]  page_we = '0;
   logic [15:0] page_data = '0;
   logic [15:0] cmd_rdata, instr_word, cfg_ctrl, cfg_seg, cfg_addr, cfg_mask1, cfg_mask2;
   logic        instr_valid, bank_bg;

   int checks = 0, errors = 0, cycles = 0;
   logic [15:0] last_rd;
   logic        last_iv;
   logic [15:0] last_iw;

   // reference model state
   int  m_cfg [2][4];
   int  m_mask2, m_psrc [2], m_pdst [2];
   bit  m_ovr, m_used, m_bg, m_iv, m_wrq, m_rdq;
   int  m_tgt, m_iw;

   always #5 clk = ~clk;

   cmd_port_ovr i_cmd_port_ovr (
      .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_rd(cmd_rd), .cmd_wdata(cmd_wdata),
      .status_in(status_in), .flags_in(flags_in), .page_we(page_we), .page_data(page_data),
      .cmd_rdata(cmd_rdata), .instr_valid(instr_valid), .instr_word(instr_word),
      .bank_bg(bank_bg), .cfg_ctrl(cfg_ctrl), .cfg_seg(cfg_seg), .cfg_addr(cfg_addr),
      .cfg_mask1(cfg_mask1), .cfg_mask2(cfg_mask2)
   );

   function automatic int m_read(int t);
      int b = m_bg ? 1 : 0;
      if (t < 4)  return m_cfg[b][t];
      if (t == 4) return m_mask2;
      if (t == 5) return {DEV, m_psrc[b][3:0]};
      if (t == 6) return m_pdst[b];
      return flags_in;
   endfunction

   always @(posedge clk) begin
      bit wr_r, wr_f, rd_r, rd_f, was_ovr;
      int b;
      if (!rst_n) begin
         foreach (m_cfg[i, j]) m_cfg[i][j] = 0;
         m_mask2 = 0; m_psrc = '{0, 0}; m_pdst = '{0, 0};
         m_ovr = 0; m_used = 0; m_bg = 0; m_iv = 0; m_iw = 0; m_tgt = 0;
         m_wrq = 0; m_rdq = 0;
      end else begin
         wr_r = cmd_wr && !m_wrq; wr_f = !cmd_wr && m_wrq;
         rd_r = cmd_rd && !m_rdq; rd_f = !cmd_rd && m_rdq;
         b = m_bg ? 1 : 0;
         was_ovr = m_ovr;
         m_iv = 0;
         if (page_we[0]) m_psrc[b] = page_data[3:0];
         if (page_we[1]) m_pdst[b] = page_data;
         if (wr_r && was_ovr) begin
            if (m_tgt < 4) m_cfg[b][m_tgt] = cmd_wdata;
            else if (m_tgt == 4) m_mask2 = cmd_wdata;
         end else if (wr_r) begin
            m_iv = 1; m_iw = cmd_wdata;
            if ((cmd_wdata & 16'hFFC7) == 16'h0200) begin m_ovr = 1; m_tgt = (cmd_wdata >> 3) & 7; end
            if (cmd_wdata == 16'h0600) m_bg = 0;
            if (cmd_wdata == 16'h0601) m_bg = 1;
         end
         if (was_ovr && m_used && (wr_f || rd_f)) begin m_ovr = 0; m_used = 0; end
         else if (was_ovr && (wr_r || rd_r)) m_used = 1;
         m_wrq = cmd_wr; m_rdq = cmd_rd;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cycles);
      end
   endtask

   // per-clock comparison against the model
   always @(negedge clk) begin
      int b;
      #1;
      if (rst_n) begin
         b = m_bg ? 1 : 0;
         check(cmd_rdata == (m_ovr ? 16'(m_read(m_tgt)) : status_in), "R4 rdata",
               cmd_rdata, m_ovr ? m_read(m_tgt) : status_in);
         check(instr_valid == m_iv, "R2 valid", instr_valid, m_iv);
         if (m_iv) check(instr_word == 16'(m_iw), "R2 word", instr_word, m_iw);
         check(bank_bg == m_bg, "R9 bank", bank_bg, m_bg);
         check({cfg_ctrl, cfg_seg, cfg_addr, cfg_mask1, cfg_mask2} ==
               {16'(m_cfg[b][0]), 16'(m_cfg[b][1]), 16'(m_cfg[b][2]), 16'(m_cfg[b][3]), 16'(m_mask2)},
               "R5 cfg", cfg_ctrl, m_cfg[b][0]);
      end
   end

   task automatic cmd_write(input logic [15:0] w);
      @(negedge clk); cmd_wr = 1'b1; cmd_wdata = w;
      @(negedge clk); last_iv = instr_valid; last_iw = instr_word; cmd_wr = 1'b0;
      @(negedge clk);
   endtask

   task automatic cmd_read();
      @(negedge clk); cmd_rd = 1'b1;
      @(negedge clk); last_rd = cmd_rdata; cmd_rd = 1'b0;
      @(negedge clk);
   endtask

   task automatic ovr_read(input int code, input logic [15:0] exp, input string req);
      cmd_write(16'h0200 | 16'(code << 3));
      cmd_read();
      check(last_rd == exp, req, last_rd, exp);
   endtask

   task automatic ovr_write(input int code, input logic [15:0] w);
      cmd_write(16'h0200 | 16'(code << 3));
      cmd_write(w);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         errors++;
         $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(cmd_rdata == status_in && !instr_valid && !bank_bg, "R1 reset", cmd_rdata, status_in);
      check({cfg_ctrl, cfg_seg, cfg_addr, cfg_mask1, cfg_mask2} == '0, "R1 cfg zero", cfg_ctrl, 0);

      // R2 default forwarding
      cmd_write(16'h1234);
      check(last_iv && last_iw == 16'h1234, "R2 forward", last_iw, 16'h1234);
      cmd_read();
      check(last_rd == status_in, "R4 status read", last_rd, status_in);

      // R5 overridden writes to writable targets
      ovr_write(0, 16'hBEEF);
      check(!last_iv, "R2 no forward under override", last_iv, 0);
      check(cfg_ctrl == 16'hBEEF, "R5 ctrl", cfg_ctrl, 16'hBEEF);
      ovr_write(1, 16'h1111);
      ovr_write(2, 16'h2222);
      ovr_write(3, 16'h3333);
      ovr_write(4, 16'h4444);
      check(cfg_mask2 == 16'h4444, "R5 mask2", cfg_mask2, 16'h4444);
      ovr_read(2, 16'h2222, "R4 read addr");
      ovr_read(3, 16'h3333, "R4 read mask1");

      // R7 one-shot: second read returns status
      cmd_read();
      check(last_rd == status_in, "R7 default after use", last_rd, status_in);

      // R8 / R10 page-source with device ID
      @(negedge clk); page_we = 2'b11; page_data = 16'hC0D5;
      @(negedge clk); page_we = 2'b00;
      ovr_read(5, {DEV, 4'h5}, "R8 device id");
      ovr_read(6, 16'hC0D5, "R10 page dest");

      // R6 read-only targets ignore writes
      ovr_write(5, 16'hFFFF);
      check(!last_iv, "R6 not forwarded", last_iv, 0);
      ovr_read(5, {DEV, 4'h5}, "R6 page source kept");
      ovr_write(6, 16'h0000);
      ovr_read(6, 16'hC0D5, "R6 page dest kept");
      ovr_write(7, 16'h0000);
      ovr_read(7, flags_in, "R6 flags read");
      cmd_read();
      check(last_rd == status_in, "R6 override consumed", last_rd, status_in);

      // R3 near-miss word does not arm
      cmd_write(16'h0201);
      cmd_read();
      check(last_rd == status_in, "R3 near miss", last_rd, status_in);

      // R9 bank switching
      cmd_write(16'h0601);
      check(bank_bg && cfg_ctrl == 16'h0000, "R9 background fresh", cfg_ctrl, 0);
      ovr_write(0, 16'h7777);
      check(cfg_mask2 == 16'h4444, "R9 mask2 shared", cfg_mask2, 16'h4444);
      cmd_write(16'h0600);
      check(!bank_bg && cfg_ctrl == 16'hBEEF, "R9 foreground restored", cfg_ctrl, 16'hBEEF);
      cmd_write(16'h0601);
      ovr_read(0, 16'h7777, "R9 background read");

      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule